// File: doc/BRIEF.md
# Atomic Split-Word Snapshot Register

This block holds the most recent 48-bit next-page word delivered by an auto-negotiation receiver and shows it to software as two read-only 32-bit registers. A receiver pulses a valid strobe with the word, and the block keeps it in a live buffer. Software reads the low register first. That read returns bits [31:0] of the live word and, on the same edge, copies bits [47:32] of that same word into a private shadow. The shadow is then held for the high register.

The high register returns only the shadow, and only while a snapshot is pending. A high read consumes the snapshot. Words that arrive between the two reads update the live buffer but never the shadow, so the two halves a host reads always come from one received word. A second low read before the high read takes a fresh snapshot from the current word. Read data is registered and appears one clock after the read strobe.

Top module: `sws_snapshot_regs`

## Requirements
- R1: After a synchronous active-high reset, rd_data is zero, the live word is zero and no snapshot is pending.
- R2: A read strobe at the low-register address (offset 0) returns bits [31:0] of the live word, as held before that clock edge, on rd_data one cycle later. A word strobed in the same cycle is not seen by that read.
- R3: A low-register read copies bits [47:32] of the same live word into the shadow and marks a snapshot pending. A following read at the high-register address (offset 1) returns that shadow in bits [15:0] of rd_data. Bits [31:16] of rd_data are zero.
- R4: While a snapshot is pending, incoming words update the live buffer only, and the value the high register returns does not change.
- R5: A high-register read releases the snapshot. Any further high read returns zero until the next low read.
- R6: A high-register read with no earlier low read since reset returns zero.
- R7: A second low read before the high read re-captures the upper bits from the live word current at that second read.
- R8: A read at any other address returns zero and changes neither the live word, the shadow nor the pending state.
- R9: In a cycle without a read strobe, rd_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | Strobe: word_data holds a new received word |
| word_data | input | 48 | Received next-page word |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register offset: 0 low half, 1 high half |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |

## Verification
On every cycle the assertions check four things: the shadow changes only on a low read, the pending flag follows low and high reads, a low read returns the live word's low bits, and a high read returns zero in the reserved bits, or zero overall when nothing is pending. Other properties need an ordered history of words and reads, which only the bench's scenarios provide. These cover the coherence of the two halves while new words arrive, re-snapshots, high reads repeated after release, and unmapped reads that must leave the state untouched. The bench's reference model checks rd_data against that history on every clock.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE     = 2'd0,
    SEL_LO       = 2'd1,
    SEL_HI       = 2'd2,
    SEL_UNMAPPED = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sws_addr_decode.sv
module sws_addr_decode
  import sws_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] LoOff = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HiOff = ADDR_W'(HI_ADDR);

  always_comb begin
    if (!rd_en)                sel = SEL_IDLE;
    else if (rd_addr == LoOff) sel = SEL_LO;
    else if (rd_addr == HiOff) sel = SEL_HI;
    else                       sel = SEL_UNMAPPED;
  end

endmodule

// File: rtl/sws_live_buf.sv
module sws_live_buf #(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  output logic [WORD_W-1:0] live_q
);

  always_ff @(posedge clk) begin
    if (rst)           live_q <= '0;
    else if (word_vld) live_q <= word_data;
  end

endmodule

// File: rtl/sws_snapshot.sv
module sws_snapshot
  import sws_pkg::*;
#(
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  reg_sel_e        sel,
  input  logic [HI_W-1:0] live_hi,
  output logic [HI_W-1:0] shadow_q,
  output logic            pending_q
);

  // The shadow loads only on a low read; incoming words never reach it.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      case (sel)
        SEL_LO: begin
          shadow_q  <= live_hi;
          pending_q <= 1'b1;
        end
        SEL_HI:  pending_q <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_LO) |=> $stable(shadow_q)); // R4

  AST_LOCK_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_LO) |=> (pending_q && shadow_q == $past(live_hi))); // R3

  AST_RELEASE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_HI) |=> !pending_q); // R5

  AST_UNMAPPED_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_UNMAPPED) |=> $stable(pending_q)); // R8

endmodule

// File: rtl/sws_rd_port.sv
module sws_rd_port
  import sws_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int HI_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] live_lo,
  input  logic [HI_W-1:0]  shadow,
  input  logic             pending,
  output logic [REG_W-1:0] rd_data_q
);

  localparam int PAD_W = REG_W - HI_W;

  logic [REG_W-1:0] hi_view;
  assign hi_view = pending ? {{PAD_W{1'b0}}, shadow} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else begin
      case (sel)
        SEL_LO:       rd_data_q <= live_lo;
        SEL_HI:       rd_data_q <= hi_view;
        SEL_UNMAPPED: rd_data_q <= '0;
        default:      ;
      endcase
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_HI) |=> (rd_data_q[REG_W-1:HI_W] == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_IDLE) |=> $stable(rd_data_q)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_UNMAPPED) |=> (rd_data_q == '0)); // R8

endmodule

// File: rtl/sws_snapshot_regs.sv
module sws_snapshot_regs
  import sws_pkg::*;
#(
  parameter int WORD_W  = 48,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);

  localparam int HI_W = WORD_W - REG_W;

  generate
    if (HI_W < 1 || HI_W >= REG_W) begin : g_bad_split
      $error("WORD_W must lie strictly between REG_W and 2*REG_W");
    end
  endgenerate

  reg_sel_e          sel;
  logic [WORD_W-1:0] live_word;
  logic [HI_W-1:0]   shadow;
  logic              pending;

  sws_addr_decode #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_decode (
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .sel    (sel)
  );

  sws_live_buf #(
    .WORD_W(WORD_W)
  ) u_live (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word_data(word_data),
    .live_q   (live_word)
  );

  sws_snapshot #(
    .HI_W(HI_W)
  ) u_snap (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .live_hi  (live_word[WORD_W-1:REG_W]),
    .shadow_q (shadow),
    .pending_q(pending)
  );

  sws_rd_port #(
    .REG_W(REG_W),
    .HI_W (HI_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .live_lo  (live_word[REG_W-1:0]),
    .shadow   (shadow),
    .pending  (pending),
    .rd_data_q(rd_data)
  );

  AST_LOW_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(LO_ADDR)) |=>
      (rd_data == $past(live_word[REG_W-1:0]))); // R2

  AST_HIGH_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(HI_ADDR) && !pending) |=> (rd_data == '0)); // R6

  AST_HIGH_MATCHES_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(HI_ADDR) && pending) |=>
      (rd_data[HI_W-1:0] == $past(shadow))); // R3

endmodule

// File: tb/sws_snapshot_regs_bench.sv
module sws_snapshot_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        word_vld;
  logic [47:0] word_data;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  // reference model state
  logic [47:0] m_live;
  logic [15:0] m_shadow;
  bit          m_pending;
  logic [31:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sws_snapshot_regs u_sws_snapshot_regs (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word_data(word_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  task automatic model_edge();
    if (rst) begin
      m_live = '0; m_shadow = '0; m_pending = 0; m_rd = '0;
    end else begin
      if (rd_en) begin
        if (rd_addr == 4'd0) begin
          m_rd = m_live[31:0];
          m_shadow = m_live[47:32];
          m_pending = 1;
        end else if (rd_addr == 4'd1) begin
          m_rd = m_pending ? {16'h0, m_shadow} : 32'h0;
          m_pending = 0;
        end else begin
          m_rd = 32'h0;
        end
      end
      if (word_vld) m_live = word_data;
    end
  endtask

  task automatic check(input logic [31:0] exp, input string req);
    vectors++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, rd_data, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit v, input logic [47:0] d, input bit re, input logic [3:0] a);
    word_vld = v; word_data = d; rd_en = re; rd_addr = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(m_rd, tag);
  endtask

  task automatic push(input logic [47:0] d); cyc(1, d, 0, 4'd0); endtask
  task automatic rd(input logic [3:0] a);    cyc(0, '0, 1, a);   endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    rst = 1; word_vld = 0; word_data = '0; rd_en = 0; rd_addr = '0;
    @(negedge clk);
    tag = "R1";
    cyc(0, '0, 0, 0);
    cyc(0, '0, 0, 0);
    rst = 0;
    check(32'h0, "R1");
    rd(4'd0); check(32'h0, "R1");

    // R6: high read without a preceding low read (pending cleared above then re-set; release first)
    rd(4'd1);
    tag = "R6";
    rd(4'd1); check(32'h0, "R6");

    // R2 and R3: basic coherent pair
    tag = "R2";
    push(48'hA1B2_C3D4_E5F6);
    rd(4'd0); check(32'hC3D4_E5F6, "R2");
    tag = "R3";
    rd(4'd1); check(32'h0000_A1B2, "R3");

    // R2: word strobed in the same cycle as the low read is not seen
    tag = "R2";
    cyc(1, 48'h1111_2222_3333, 1, 4'd0); check(32'hC3D4_E5F6, "R2");
    tag = "R3";
    rd(4'd1); check(32'h0000_A1B2, "R3");

    // R4: new words during the lock leave the high half alone
    tag = "R4";
    push(48'h7777_8888_9999);
    rd(4'd0); check(32'h8888_9999, "R4");
    push(48'hDEAD_BEEF_0001);
    push(48'hFFFF_FFFF_FFFF);
    rd(4'd1); check(32'h0000_7777, "R4");

    // R5: release after high read
    tag = "R5";
    rd(4'd1); check(32'h0, "R5");

    // R7: second low read re-snapshots
    tag = "R7";
    rd(4'd0);
    push(48'h4242_0000_0042);
    rd(4'd0); check(32'h0000_0042, "R7");
    rd(4'd1); check(32'h0000_4242, "R7");

    // R8: unmapped reads return zero and disturb nothing
    tag = "R8";
    push(48'h5A5A_1234_5678);
    rd(4'd0);
    rd(4'd7); check(32'h0, "R8");
    rd(4'd15); check(32'h0, "R8");
    rd(4'd1); check(32'h0000_5A5A, "R8");
    rd(4'd9); rd(4'd1); check(32'h0, "R8");

    // R9: hold with no strobe
    tag = "R9";
    rd(4'd0);
    push(48'h0);
    cyc(0, '0, 0, 0); check(32'h1234_5678, "R9");
    cyc(0, '0, 0, 0); check(32'h1234_5678, "R9");

    // random traffic, compared on every clock
    tag = "R2/R3/R4 random";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) == 0, {$urandom, $urandom} , ($urandom % 2) == 0,
          (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 2));
    end

    // R1: reset mid-run clears state
    tag = "R1";
    push(48'h9999_9999_9999);
    rd(4'd0);
    rst = 1;
    cyc(0, '0, 0, 0);
    rst = 0;
    check(32'h0, "R1");
    rd(4'd1); check(32'h0, "R1");
    rd(4'd0); check(32'h0, "R1");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule